// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Tracker

This block sits on the controller side of a four-bank SDRAM and watches every command the scheduler issues. For each bank it follows a burst that was issued with auto precharge. It knows when that bank will start its internal precharge and when the bank becomes idle again. The scheduler can then interleave traffic to other banks without keeping its own per-bank timers.

A burst with auto precharge may be cut short by a READ or WRITE to another bank. If the interrupted burst was a read, its precharge starts right away. If it was a write, the bank first waits out the write-recovery time. The block also tracks which bank owns the read data on the bus, after the programmed CAS latency.

Before a write may cut into a read burst, the data mask must be raised. The block holds a mask request open from a mask command until the write arrives, and it flags a write that comes too early. It also flags any READ or WRITE aimed at a bank that is still busy; such a command is otherwise ignored. The clock enable freezes all tracking.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After reset every bank reads idle (`bank_idle` all ones, `bank_busy` all zeros), and `pre_start`, `dqm_req`, `violation` and `rd_data_vld` are low.
- R2: Command codes are 0 no-op, 1 READ, 2 WRITE, 3 mask request. A READ with `ap`=1 to an idle bank in cycle 0, if nothing interrupts it, makes that bank busy in cycles 1 to BL-1. It raises that bank's `pre_start` in cycle BL only, makes the bank neither busy nor idle while it precharges, and makes it idle from cycle BL+TRP.
- R3: A WRITE with `ap`=1 to an idle bank in cycle 0, if nothing interrupts it, makes that bank busy in cycles 1 to BL+TWR-1. It raises `pre_start` in cycle BL+TWR and makes the bank idle from cycle BL+TWR+TRP.
- R4: When bank n is busy in a read burst with auto precharge and an accepted READ or WRITE to another bank arrives in cycle T, `pre_start` of bank n rises in cycle T+1 and bank n is idle from cycle T+1+TRP.
- R5: When bank n is in the data phase of a write burst with auto precharge and an accepted READ or WRITE to another bank arrives in cycle T, bank n stays busy through cycle T+TWR. Its `pre_start` rises in cycle T+TWR+1, and the bank is idle from cycle T+TWR+1+TRP.
- R6: A READ or WRITE to a bank that is not idle is rejected. `violation` is high in the next cycle, and if the following command is legal it is high for that one cycle only. The rejected command changes no bank's timing, not even that of a bank running an auto-precharge read burst.
- R7: A READ or WRITE with `ap`=0 to an idle bank leaves that bank idle. It still interrupts an auto-precharge burst on another bank.
- R8: A mask request in cycle M drives `dqm_req` high from cycle M+1 up to and including the cycle of the next accepted WRITE. `dqm_req` is low from the cycle after that WRITE.
- R9: An accepted WRITE in cycle T, arriving while some bank is busy in an auto-precharge read burst, raises `violation` in cycle T+1 unless `dqm_req` was high in both cycles T-2 and T-1. The write still takes effect as in R4.
- R10: An accepted READ to bank b in cycle T gives `rd_data_vld`=1 and `rd_data_bank`=b in cycles T+CL to T+CL+BL-1, with CL=3 when `cl3`=1 and CL=2 otherwise. A later accepted READ in cycle T' takes over the bus from T'+CL. An accepted WRITE in cycle T' ends the read data from T'+CL.
- R11: While `cke` is low, commands are ignored and all state, counters and outputs hold. A frozen cycle does not count toward any delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes tracking |
| cmd | input | 2 | Command code: 0 no-op, 1 READ, 2 WRITE, 3 mask request |
| bank | input | $clog2(NBANK) | Target bank of the command |
| ap | input | 1 | Auto-precharge flag for READ/WRITE |
| cl3 | input | 1 | CAS latency select: 1 gives 3 cycles, 0 gives 2 |
| bank_busy | output | NBANK | Bank is in a burst or in write recovery |
| bank_idle | output | NBANK | Bank is idle and may accept a command |
| pre_start | output | NBANK | One-cycle pulse in the first precharge cycle |
| dqm_req | output | 1 | Data-mask request |
| rd_data_vld | output | 1 | Read data expected on the bus this cycle |
| rd_data_bank | output | $clog2(NBANK) | Bank owning the read data |
| violation | output | 1 | Rejected command or mask window not met |

## Verification
The hardest case to reach is a mask window that is one cycle short. It needs three things in a tight order: a mask request, then an auto-precharge read that keeps a burst running, then a write to a third bank only one cycle after the mask went high. The directed stimulus places the mask request before the read so that the write still lands inside the burst. It then moves the write by one cycle to show both the flagged and the clean outcome. The second awkward case is a rejected command to a precharging bank while another bank runs a read burst. This case shows that the rejected command does not count as an interruption.

// File: rtl/sdram_ap_pkg.sv
package sdram_ap_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_MASK  = 2'd3
  } ap_cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_RD_AP,
    BK_WR_AP,
    BK_WR_REC,
    BK_PRECHG
  } bank_st_e;

  // Mask must lead an interrupting write by this many cycles.
  localparam int unsigned DQM_LEAD = 2;
  // Deepest CAS latency supported by the read-data lane.
  localparam int unsigned CL_MAX = 3;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Cycles in burst state after the command cycle.
  function automatic int unsigned burst_load(int unsigned bl);
    return bl - 1;
  endfunction

  // Cycles from command to first precharge cycle when uninterrupted.
  function automatic int unsigned pre_offset(logic is_wr, int unsigned bl, int unsigned twr);
    return bl + (is_wr ? twr : 0);
  endfunction

  function automatic logic lead_met(int unsigned held);
    return held >= DQM_LEAD;
  endfunction

endpackage

// File: rtl/ap_bank_fsm.sv
module ap_bank_fsm
  import sdram_ap_pkg::*;
#(
  parameter int unsigned BL  = 4,
  parameter int unsigned TWR = 2,
  parameter int unsigned TRP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic start_rd,
  input  logic start_wr,
  input  logic intr,
  output logic busy,
  output logic idle,
  output logic in_rd_burst,
  output logic pre_start
);

  localparam int unsigned CMAX = max3(BL, TWR, TRP);
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned AW   = $clog2(BL + TWR + TRP + 2);

  bank_st_e st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic cnt_last;

  assign cnt_last = (cnt == CW'(1));

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      BK_IDLE: begin
        if (start_rd || start_wr) begin
          st_nx  = start_wr ? BK_WR_AP : BK_RD_AP;
          cnt_nx = CW'(burst_load(BL));
        end
      end
      BK_RD_AP: begin
        if (intr || cnt_last) begin
          st_nx  = BK_PRECHG;
          cnt_nx = CW'(TRP);
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      BK_WR_AP: begin
        if (intr || cnt_last) begin
          st_nx  = BK_WR_REC;
          cnt_nx = CW'(TWR);
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      BK_WR_REC: begin
        if (cnt_last) begin
          st_nx  = BK_PRECHG;
          cnt_nx = CW'(TRP);
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      BK_PRECHG: begin
        if (cnt_last) begin
          st_nx  = BK_IDLE;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      default: begin
        st_nx  = BK_IDLE;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else if (cke) begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign busy        = (st == BK_RD_AP) || (st == BK_WR_AP) || (st == BK_WR_REC);
  assign idle        = (st == BK_IDLE);
  assign in_rd_burst = (st == BK_RD_AP);
  assign pre_start   = (st == BK_PRECHG) && (cnt == CW'(TRP));

  // Elapsed-cycle tracking used only by the assertions below.
  logic [AW-1:0] age;
  logic          intr_seen;
  logic          was_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age       <= '0;
      intr_seen <= 1'b0;
      was_wr    <= 1'b0;
    end else if (cke) begin
      if ((st == BK_IDLE) && (start_rd || start_wr)) begin
        age       <= AW'(1);
        intr_seen <= 1'b0;
        was_wr    <= start_wr;
      end else if (st != BK_IDLE) begin
        if (age != '1) age <= age + 1'b1;
        if (intr && ((st == BK_RD_AP) || (st == BK_WR_AP))) intr_seen <= 1'b1;
      end
    end
  end

  // R2 and R3: uninterrupted bursts reach precharge at the nominal offset.
  p_nominal_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_start && !intr_seen) |-> (32'(age) == pre_offset(was_wr, BL, TWR)));

  p_rd_intr_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && intr && (st == BK_RD_AP)) |=> pre_start);

  p_wr_intr_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && intr && (st == BK_WR_AP)) |=> ((st == BK_WR_REC) && (cnt == CW'(TWR))));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(st) && $stable(cnt)));

endmodule

// File: rtl/ap_dqm_guard.sv
module ap_dqm_guard
  import sdram_ap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic mask_cmd,
  input  logic wr_acc,
  input  logic rd_ap_live,
  output logic dqm_req,
  output logic win_short
);

  localparam int unsigned HW = $clog2(DQM_LEAD + 1);

  logic [HW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_req <= 1'b0;
      held    <= '0;
    end else if (cke) begin
      if (wr_acc) dqm_req <= 1'b0;
      else if (mask_cmd) dqm_req <= 1'b1;

      if (wr_acc || !dqm_req) held <= '0;
      else if (held != HW'(DQM_LEAD)) held <= held + 1'b1;
    end
  end

  assign win_short = wr_acc && rd_ap_live && !lead_met(32'(held));

  p_dqm_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && mask_cmd) |=> dqm_req);

  p_dqm_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && wr_acc) |=> !dqm_req);

endmodule

// File: rtl/ap_rd_lane.sv
module ap_rd_lane
  import sdram_ap_pkg::*;
#(
  parameter int unsigned BL = 4,
  parameter int unsigned BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cl3,
  input  logic          rd_acc,
  input  logic          wr_acc,
  input  logic [BW-1:0] bank,
  output logic          data_vld,
  output logic [BW-1:0] data_bank
);

  localparam int unsigned LW = $clog2(BL + 1);

  logic [LW-1:0] rd_left;
  logic [BW-1:0] rd_bank;
  logic          beat_v;
  logic [BW-1:0] beat_b;
  logic          p_v [CL_MAX];
  logic [BW-1:0] p_b [CL_MAX];

  always_comb begin
    if (rd_acc) begin
      beat_v = 1'b1;
      beat_b = bank;
    end else begin
      beat_v = !wr_acc && (rd_left != '0);
      beat_b = rd_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_left <= '0;
      rd_bank <= '0;
      for (int s = 0; s < CL_MAX; s++) begin
        p_v[s] <= 1'b0;
        p_b[s] <= '0;
      end
    end else if (cke) begin
      if (rd_acc) begin
        rd_left <= LW'(burst_load(BL));
        rd_bank <= bank;
      end else if (wr_acc) begin
        rd_left <= '0;
      end else if (rd_left != '0) begin
        rd_left <= rd_left - 1'b1;
      end
      p_v[0] <= beat_v;
      p_b[0] <= beat_b;
      for (int s = 1; s < CL_MAX; s++) begin
        p_v[s] <= p_v[s-1];
        p_b[s] <= p_b[s-1];
      end
    end
  end

  assign data_vld  = cl3 ? p_v[CL_MAX-1] : p_v[CL_MAX-2];
  assign data_bank = cl3 ? p_b[CL_MAX-1] : p_b[CL_MAX-2];

  p_lane_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $stable(cl3)) |=> ($stable(data_vld) && $stable(data_bank)));

endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_ap_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned BL    = 4,
  parameter int unsigned TWR   = 2,
  parameter int unsigned TRP   = 3,
  localparam int unsigned BW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [1:0]       cmd,
  input  logic [BW-1:0]    bank,
  input  logic             ap,
  input  logic             cl3,
  output logic [NBANK-1:0] bank_busy,
  output logic [NBANK-1:0] bank_idle,
  output logic [NBANK-1:0] pre_start,
  output logic             dqm_req,
  output logic             rd_data_vld,
  output logic [BW-1:0]    rd_data_bank,
  output logic             violation
);

  logic             cmd_rw, tgt_idle, acc, rej;
  logic             rd_acc, wr_acc, mask_cmd;
  logic [NBANK-1:0] in_rd_burst;
  logic             rd_ap_live, win_short;

  assign cmd_rw   = cke && ((cmd == CMD_READ) || (cmd == CMD_WRITE));
  assign tgt_idle = bank_idle[bank];
  assign acc      = cmd_rw && tgt_idle;
  assign rej      = cmd_rw && !tgt_idle;
  assign rd_acc   = acc && (cmd == CMD_READ);
  assign wr_acc   = acc && (cmd == CMD_WRITE);
  assign mask_cmd = cke && (cmd == CMD_MASK);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic own;
    assign own = (bank == BW'(i));

    ap_bank_fsm #(.BL(BL), .TWR(TWR), .TRP(TRP)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke        (cke),
      .start_rd   (rd_acc && ap && own),
      .start_wr   (wr_acc && ap && own),
      .intr       (acc && !own),
      .busy       (bank_busy[i]),
      .idle       (bank_idle[i]),
      .in_rd_burst(in_rd_burst[i]),
      .pre_start  (pre_start[i])
    );
  end

  assign rd_ap_live = |in_rd_burst;

  ap_dqm_guard u_dqm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .mask_cmd  (mask_cmd),
    .wr_acc    (wr_acc),
    .rd_ap_live(rd_ap_live),
    .dqm_req   (dqm_req),
    .win_short (win_short)
  );

  ap_rd_lane #(.BL(BL), .BW(BW)) u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .cl3      (cl3),
    .rd_acc   (rd_acc),
    .wr_acc   (wr_acc),
    .bank     (bank),
    .data_vld (rd_data_vld),
    .data_bank(rd_data_bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else if (cke) violation <= rej || win_short;
  end

  p_ap_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && ap) |=> bank_busy[$past(bank)]);

  p_reject_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> violation);

  p_short_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_short |=> violation);

  p_plain_stays_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ap) |=> bank_idle[$past(bank)]);

endmodule

// File: tb/sdram_ap_tracker_test.sv
module sdram_ap_tracker_test;
  localparam int BL  = 4;
  localparam int TWR = 2;
  localparam int TRP = 3;
  localparam logic [1:0] NOP = 2'd0, RD = 2'd1, WR = 2'd2, MSK = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n, cke, ap, cl3;
  logic [1:0] cmd, bank;
  logic [3:0] bank_busy, bank_idle, pre_start;
  logic       dqm_req, rd_data_vld, violation;
  logic [1:0] rd_data_bank;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  sdram_ap_tracker #(.NBANK(4), .BL(BL), .TWR(TWR), .TRP(TRP)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .ap(ap), .cl3(cl3),
    .bank_busy(bank_busy), .bank_idle(bank_idle), .pre_start(pre_start),
    .dqm_req(dqm_req), .rd_data_vld(rd_data_vld), .rd_data_bank(rd_data_bank),
    .violation(violation)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv(input logic [1:0] c, input logic [1:0] b, input logic a);
    cmd = c; bank = b; ap = a;
  endtask

  task automatic ck(input string req, input int k, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", req, k, got, exp);
    end
  endtask

  // {busy, pre_start, idle} of one bank against its expected timeline
  task automatic ck_bank(input string req, input int k, input int b,
                         input int bfrom, input int bto, input int pre_at, input int idle_at);
    logic [7:0] e;
    e = {5'd0, (k >= bfrom && k <= bto), (k == pre_at), (k < bfrom || k >= idle_at)};
    ck(req, k, {5'd0, bank_busy[b], pre_start[b], bank_idle[b]}, e);
  endtask

  function automatic logic [7:0] lane_exp(input logic v, input logic [1:0] b);
    return v ? {5'd0, 1'b1, b} : 8'd0;
  endfunction

  function automatic logic [7:0] lane_got();
    return rd_data_vld ? {5'd0, 1'b1, rd_data_bank} : 8'd0;
  endfunction

  task automatic settle();
    drv(NOP, 0, 0); cke = 1'b1; cl3 = 1'b0;
    repeat (12) tick();
  endtask

  task automatic t_reset();
    ck("R1", 0, {4'd0, bank_idle}, 8'h0F);
    ck("R1", 0, {4'd0, bank_busy}, 8'h00);
    ck("R1", 0, {4'd0, pre_start}, 8'h00);
    ck("R1", 0, {7'd0, dqm_req}, 8'h00);
    ck("R1", 0, {7'd0, violation}, 8'h00);
    ck("R1", 0, {7'd0, rd_data_vld}, 8'h00);
  endtask

  task automatic t_read_plain();
    for (int k = 0; k <= 9; k++) begin
      ck_bank("R2", k, 0, 1, BL-1, BL, BL+TRP);
      ck("R10", k, lane_got(), lane_exp(k >= 2 && k <= 5, 2'd0));
      if (k == 0) drv(RD, 0, 1); else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_write_plain();
    for (int k = 0; k <= 11; k++) begin
      ck_bank("R3", k, 1, 1, BL+TWR-1, BL+TWR, BL+TWR+TRP);
      if (k == 0) drv(WR, 1, 1); else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_read_by_read();
    for (int k = 0; k <= 9; k++) begin
      ck_bank("R4", k, 0, 1, 2, 3, 6);
      ck_bank("R7", k, 2, 100, -1, -1, 100);
      ck("R10", k, lane_got(),
         (k >= 2 && k <= 3) ? lane_exp(1'b1, 2'd0) : lane_exp(k >= 4 && k <= 7, 2'd2));
      if (k == 0) drv(RD, 0, 1);
      else if (k == 2) drv(RD, 2, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_read_by_write();
    for (int k = 0; k <= 9; k++) begin
      ck_bank("R4", k, 0, 2, 3, 4, 7);
      ck_bank("R7", k, 1, 100, -1, -1, 100);
      ck("R8", k, {7'd0, dqm_req}, {7'd0, (k >= 1 && k <= 3)});
      ck("R9", k, {7'd0, violation}, 8'd0);
      if (k == 0) drv(MSK, 0, 0);
      else if (k == 1) drv(RD, 0, 1);
      else if (k == 3) drv(WR, 1, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_mask_short();
    for (int k = 0; k <= 7; k++) begin
      ck("R9", k, {7'd0, violation}, {7'd0, (k == 3)});
      ck_bank("R4", k, 0, 2, 2, 3, 6);
      if (k == 0) drv(MSK, 0, 0);
      else if (k == 1) drv(RD, 0, 1);
      else if (k == 2) drv(WR, 2, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_write_cut();
    for (int k = 0; k <= 9; k++) begin
      ck_bank("R5", k, 0, 1, 4, 5, 8);
      ck("R5", k, {7'd0, violation}, 8'd0);
      if (k == 0) drv(WR, 0, 1);
      else if (k == 2) drv(WR, 1, 0);
      else drv(NOP, 0, 0);
      tick();
    end
    settle();
    for (int k = 0; k <= 8; k++) begin
      ck_bank("R5", k, 3, 1, 3, 4, 7);
      if (k == 0) drv(WR, 3, 1);
      else if (k == 1) drv(RD, 2, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_reject();
    for (int k = 0; k <= 9; k++) begin
      ck_bank("R6", k, 0, 1, 1, 2, 5);
      ck_bank("R6", k, 1, 2, 4, 5, 8);
      ck("R6", k, {7'd0, violation}, {7'd0, (k == 3 || k == 4)});
      if (k == 0) drv(RD, 0, 1);
      else if (k == 1) drv(RD, 1, 1);
      else if (k == 2) drv(WR, 1, 0);
      else if (k == 3) drv(RD, 0, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_freeze();
    for (int k = 0; k <= 10; k++) begin
      ck_bank("R11", k, 0, 1, 5, 6, 9);
      ck_bank("R11", k, 1, 100, -1, -1, 100);
      cke = !(k == 2 || k == 3);
      if (k == 0) drv(RD, 0, 1);
      else if (k == 2 || k == 3) drv(RD, 1, 1);
      else drv(NOP, 0, 0);
      tick();
    end
    cke = 1'b1;
  endtask

  task automatic t_lane();
    cl3 = 1'b1;
    for (int k = 0; k <= 8; k++) begin
      ck("R10", k, lane_got(), lane_exp(k >= 3 && k <= 6, 2'd3));
      if (k == 0) drv(RD, 3, 0); else drv(NOP, 0, 0);
      tick();
    end
    settle();
    for (int k = 0; k <= 7; k++) begin
      ck("R10", k, lane_got(), lane_exp(k >= 2 && k <= 3, 2'd1));
      if (k == 0) drv(RD, 1, 0);
      else if (k == 2) drv(WR, 2, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  task automatic t_mask_hold();
    for (int k = 0; k <= 7; k++) begin
      ck("R8", k, {7'd0, dqm_req}, {7'd0, (k >= 1 && k <= 4)});
      ck("R8", k, {7'd0, violation}, 8'd0);
      if (k == 0) drv(MSK, 0, 0);
      else if (k == 4) drv(WR, 0, 0);
      else drv(NOP, 0, 0);
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cl3 = 1'b0;
    drv(NOP, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read_plain();   settle();
    t_write_plain();  settle();
    t_read_by_read(); settle();
    t_read_by_write(); settle();
    t_mask_short();   settle();
    t_write_cut();    settle();
    t_reject();       settle();
    t_freeze();       settle();
    t_lane();         settle();
    t_mask_hold();    settle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule